// File: doc/BRIEF.md
# ATA Task-File Register Block

This block is the device-side register interface of a legacy parallel ATA drive. A host bus front end, already synchronised to the core clock, presents two active-low chip selects, a 3-bit register address and single-cycle read and write strobes. The block decodes these into the command block (a 16-bit data port and seven byte-wide registers) and the control block (alternate status, device control and a drive address readback). Read data is a combinational function of the current selection; side effects of a read, such as clearing the interrupt, happen on the clock edge that ends the read strobe cycle.

Command bytes are classified on the spot. Media commands (recalibrate, read sector, write sector, seek, identify) are handed to a backend through a one-cycle strobe, and the block stays busy until the backend reports completion. Power commands and unknown codes are finished inside the block one cycle after acceptance. The data port is a pass-through to the backend with its own read and write strobes. An idle timer can spin the drive down after a programmed period without activity. The timeout is taken from the sector count byte, in 5-second units for one command family and 0.1-second units for the other. The length of 0.1 s in clock cycles is a parameter.

Top module: `ata_taskfile_regs`

## Requirements
- R1: With cs0_n low and cs1_n high, addresses 2, 3, 4 and 5 read back the last byte written to sector count, sector number, cylinder low and cylinder high. Reads with both selects equal, or through cs1_n at addresses 0 to 5, return zero. Writes with both selects equal, or through cs1_n at address 2, change no register.
- R2: After reset, sector count and sector number read 01h, both cylinder bytes 00h, drive/head A0h, status 50h, error 00h and drive address 3Dh. intrq is low and spindle_on is high.
- R3: Drive/head (primary, address 6) stores bits 4..0 (bit 4 selects the slave device, bits 3..0 are the head) and always reads with bits 7..5 equal to 101b.
- R4: The drive address register (cs1_n low, address 7) reads as {0, writing, ~head[3:0], slave, ~slave}. The writing bit is 1 while a write-sector command (30h/31h) is busy.
- R5: While BSY is set, writes to the command-block byte registers and the command register are ignored.
- R6: An accepted command write sets BSY (status 80h when DRQ is low) and clears ERR, the error register and the pending interrupt. A media command pulses cmd_stb for one cycle, one cycle after the write, with cmd_code holding the byte. be_done then clears BSY and raises intrq.
- R7: A read of primary status (address 7, cs0_n low) clears intrq. A read of alternate status (address 6, cs1_n low) returns the same byte (status bits: 7 BSY, 6 RDY, 4 seek complete, 3 DRQ, 0 ERR) and leaves intrq set.
- R8: With device control bit 1 set, a completion does not raise intrq, and clearing the bit afterwards does not raise it either.
- R9: A command code outside the supported set completes one cycle after acceptance without cmd_stb, with status ERR set and error register 04h (aborted).
- R10: A backend completion with be_fail set loads be_error into the error register and sets ERR.
- R11: Writing device control with bit 2 set returns every register, BSY, the interrupt and the spindle to their reset values in that cycle.
- R12: E0h turns spindle_on off and E1h turns it on. E2h/F2h turn it off and E3h/F3h turn it on. Every media command turns it on.
- R13: E2h/E3h arm an idle timeout of sector count times 50 ticks, and F2h/F3h one of sector count times 1 tick, a tick being TICKS_PER_TENTH cycles; a count of zero disarms it. Any accepted command or data-port access restarts the timeout. When it runs out while spinning and not busy, spindle_on goes low.
- R14: The data port (primary, address 0) returns be_rdata on read and drives dp_wdata with the host word on write, with dp_rd_stb and dp_wr_stb high during the strobe cycle. be_drq appears as status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs0_n | input | 1 | Command-block select, active low |
| cs1_n | input | 1 | Control-block select, active low |
| addr | input | 3 | Register address |
| rd_stb | input | 1 | One-cycle host read strobe |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_data | input | DATA_W | Host write data (low byte for byte registers) |
| rd_data | output | DATA_W | Read data for the current selection |
| intrq | output | 1 | Interrupt request to the host |
| cmd_stb | output | 1 | One-cycle pulse handing a media command to the backend |
| cmd_code | output | 8 | Last accepted command byte |
| dp_rd_stb | output | 1 | Host is reading the data port |
| dp_wr_stb | output | 1 | Host is writing the data port |
| dp_wdata | output | DATA_W | Data-port word from the host |
| be_rdata | input | DATA_W | Data-port word from the backend |
| be_drq | input | 1 | Backend requests a data transfer |
| be_done | input | 1 | Backend finished the current media command |
| be_fail | input | 1 | Qualifies be_done as a failed command |
| be_error | input | 8 | Error byte reported with a failure |
| spindle_on | output | 1 | Spindle motor request |

## Verification
The assertions assume that the host never raises rd_stb and wr_stb in the same cycle and that be_done arrives only while a media command is outstanding. The stimulus drives strobes one at a time from tasks that hold each for exactly one cycle, and it issues be_done only after cmd_stb has been seen. Device control is written only between commands or as a software reset. Idle-timer windows are checked with a margin of several cycles on each side of the computed expiry, and no incidental accesses fall inside a window unless the check is about restarting the timeout.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_DATA,
      SEL_ERRFEAT,
      SEL_SCNT,
      SEL_SNUM,
      SEL_CYLL,
      SEL_CYLH,
      SEL_DRVHD,
      SEL_STATCMD,
      SEL_ALTCTL,
      SEL_DRVADR
   } tf_sel_e;

   typedef enum logic [2:0] {
      CK_BACKEND,
      CK_SPIN_DOWN,
      CK_SPIN_UP,
      CK_IDLE_DOWN,
      CK_IDLE_KEEP,
      CK_ABORT
   } cmd_kind_e;

   localparam int ST_ERR  = 0;
   localparam int ST_DRQ  = 3;
   localparam int ST_DSC  = 4;
   localparam int ST_RDY  = 6;
   localparam int ST_BSY  = 7;

   localparam int DC_NIEN = 1;
   localparam int DC_SRST = 2;

   localparam logic [7:0] ERR_ABORTED = 8'h04;

   // byte slots of the plain command-block registers, in slot order
   function automatic tf_sel_e slot_sel(input int idx);
      tf_sel_e s;
      case (idx)
         0:       s = SEL_SCNT;
         1:       s = SEL_SNUM;
         2:       s = SEL_CYLL;
         default: s = SEL_CYLH;
      endcase
      return s;
   endfunction

   function automatic cmd_kind_e classify_cmd(input logic [7:0] c);
      cmd_kind_e k;
      k = CK_ABORT;
      if (c[7:4] == 4'h1 || c[7:4] == 4'h7)
         k = CK_BACKEND;
      else if (c[7:1] == 7'h10 || c[7:1] == 7'h18 || c == 8'hEC)
         k = CK_BACKEND;
      else if (c == 8'hE0)
         k = CK_SPIN_DOWN;
      else if (c == 8'hE1)
         k = CK_SPIN_UP;
      else if (c == 8'hE2 || c == 8'hF2)
         k = CK_IDLE_DOWN;
      else if (c == 8'hE3 || c == 8'hF3)
         k = CK_IDLE_KEEP;
      return k;
   endfunction

   function automatic logic is_write_cmd(input logic [7:0] c);
      return (c[7:1] == 7'h18);
   endfunction

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
   import ata_tf_pkg::*;
(
   input  logic       cs0_n,
   input  logic       cs1_n,
   input  logic [2:0] addr,
   output tf_sel_e    sel
);

   always_comb begin
      sel = SEL_NONE;
      if (!cs0_n && cs1_n) begin
         case (addr)
            3'd0:    sel = SEL_DATA;
            3'd1:    sel = SEL_ERRFEAT;
            3'd2:    sel = SEL_SCNT;
            3'd3:    sel = SEL_SNUM;
            3'd4:    sel = SEL_CYLL;
            3'd5:    sel = SEL_CYLH;
            3'd6:    sel = SEL_DRVHD;
            default: sel = SEL_STATCMD;
         endcase
      end else if (cs0_n && !cs1_n) begin
         if (addr == 3'd6)
            sel = SEL_ALTCTL;
         else if (addr == 3'd7)
            sel = SEL_DRVADR;
      end
   end

endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
   import ata_tf_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             wr_stb,
   input  tf_sel_e          sel,
   input  logic [REG_W-1:0] wr_byte,
   input  logic             bsy,
   output logic [REG_W-1:0] scount,
   output logic [REG_W-1:0] snumber,
   output logic [REG_W-1:0] cyl_lo,
   output logic [REG_W-1:0] cyl_hi,
   output logic [4:0]       dev_head,
   output logic             nien
);

   localparam int NSLOT = 4;

   logic [NSLOT-1:0][REG_W-1:0] slot_q;

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      localparam logic [REG_W-1:0] RST_VAL = (i < 2) ? REG_W'(1) : '0;
      logic [REG_W-1:0] q;
      logic             hit;
      assign hit = wr_stb && !bsy && (sel == slot_sel(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= RST_VAL;
         else if (srst)
            q <= RST_VAL;
         else if (hit)
            q <= wr_byte;
      end
      assign slot_q[i] = q;
   end

   assign scount  = slot_q[0];
   assign snumber = slot_q[1];
   assign cyl_lo  = slot_q[2];
   assign cyl_hi  = slot_q[3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_head <= '0;
         nien     <= 1'b0;
      end else if (srst) begin
         dev_head <= '0;
         nien     <= 1'b0;
      end else if (wr_stb) begin
         if (sel == SEL_DRVHD && !bsy)
            dev_head <= wr_byte[4:0];
         if (sel == SEL_ALTCTL)
            nien <= wr_byte[DC_NIEN];
      end
   end

   // R5: a busy write to sector count leaves it unchanged
   a_r5_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && bsy && !srst && sel == SEL_SCNT) |=> $stable(scount));

endmodule

// File: rtl/ata_tf_cmd.sv
module ata_tf_cmd
   import ata_tf_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             cmd_wr,
   input  logic [REG_W-1:0] wr_byte,
   input  logic             stat_rd,
   input  logic             nien,
   input  logic             be_done,
   input  logic             be_fail,
   input  logic [REG_W-1:0] be_error,
   input  logic             timer_expire,
   output logic             bsy,
   output logic             cmd_acc,
   output logic             err,
   output logic [REG_W-1:0] err_reg,
   output logic             pend,
   output logic             cmd_stb,
   output logic [REG_W-1:0] cmd_code,
   output logic             spindle,
   output logic             writing,
   output logic             timer_load,
   output logic             timer_long
);

   typedef enum logic [1:0] {CS_IDLE, CS_BACKEND, CS_FINISH} cstate_e;

   cstate_e   state;
   logic      abort_q;
   cmd_kind_e kind;

   assign kind       = classify_cmd(wr_byte);
   assign bsy        = (state != CS_IDLE);
   assign cmd_acc    = cmd_wr && (state == CS_IDLE);
   assign timer_load = cmd_acc && (kind == CK_IDLE_DOWN || kind == CK_IDLE_KEEP);
   assign timer_long = ~wr_byte[4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= CS_IDLE;
         abort_q  <= 1'b0;
         err      <= 1'b0;
         err_reg  <= '0;
         pend     <= 1'b0;
         cmd_stb  <= 1'b0;
         cmd_code <= '0;
         spindle  <= 1'b1;
         writing  <= 1'b0;
      end else if (srst) begin
         state    <= CS_IDLE;
         abort_q  <= 1'b0;
         err      <= 1'b0;
         err_reg  <= '0;
         pend     <= 1'b0;
         cmd_stb  <= 1'b0;
         cmd_code <= '0;
         spindle  <= 1'b1;
         writing  <= 1'b0;
      end else begin
         cmd_stb <= 1'b0;
         if (timer_expire)
            spindle <= 1'b0;
         case (state)
            CS_IDLE: begin
               if (cmd_acc) begin
                  err      <= 1'b0;
                  err_reg  <= '0;
                  pend     <= 1'b0;
                  cmd_code <= wr_byte;
                  abort_q  <= (kind == CK_ABORT);
                  case (kind)
                     CK_BACKEND: begin
                        cmd_stb <= 1'b1;
                        spindle <= 1'b1;
                        writing <= is_write_cmd(wr_byte);
                        state   <= CS_BACKEND;
                     end
                     CK_SPIN_DOWN, CK_IDLE_DOWN: begin
                        spindle <= 1'b0;
                        state   <= CS_FINISH;
                     end
                     CK_SPIN_UP, CK_IDLE_KEEP: begin
                        spindle <= 1'b1;
                        state   <= CS_FINISH;
                     end
                     default: state <= CS_FINISH;
                  endcase
               end else if (stat_rd) begin
                  pend <= 1'b0;
               end
            end
            CS_BACKEND: begin
               if (be_done) begin
                  writing <= 1'b0;
                  if (be_fail) begin
                     err     <= 1'b1;
                     err_reg <= be_error;
                  end
                  if (!nien)
                     pend <= 1'b1;
                  state <= CS_IDLE;
               end else if (stat_rd) begin
                  pend <= 1'b0;
               end
            end
            default: begin
               if (abort_q) begin
                  err     <= 1'b1;
                  err_reg <= ERR_ABORTED;
               end
               abort_q <= 1'b0;
               if (!nien)
                  pend <= 1'b1;
               state <= CS_IDLE;
            end
         endcase
      end
   end

   // R6: an accepted command makes the block busy
   a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n || srst)
      cmd_acc |=> bsy);

   // R9: an unknown code ends with ERR and the aborted code
   a_r9_abort_flags: assert property (@(posedge clk) disable iff (!rst_n || srst)
      (cmd_acc && classify_cmd(wr_byte) == CK_ABORT) |=> ##1 (err && err_reg == ERR_ABORTED));

   // R7: a primary status read with no completion drops the pending interrupt
   a_r7_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && state == CS_IDLE && !cmd_acc) |=> !pend);

   // R8: while masked, no interrupt becomes pending
   a_r8_masked_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (nien && !pend) |=> !pend);

endmodule

// File: rtl/ata_tf_idle_timer.sv
module ata_tf_idle_timer #(
   parameter int TICKS_PER_TENTH = 10_000_000,
   parameter int LONG_UNIT       = 50,
   parameter int CNT_W           = $clog2(255 * LONG_UNIT + 1),
   parameter int PRE_W           = (TICKS_PER_TENTH > 2) ? $clog2(TICKS_PER_TENTH) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       srst,
   input  logic       load,
   input  logic       long_units,
   input  logic [7:0] count,
   input  logic       kick,
   input  logic       run,
   output logic       expire
);

   logic             armed;
   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] remain;
   logic [PRE_W-1:0] pre;
   logic [CNT_W-1:0] load_val;
   logic             tick_edge;

   assign load_val  = long_units ? CNT_W'(count) * CNT_W'(LONG_UNIT) : CNT_W'(count);
   assign tick_edge = (pre == PRE_W'(TICKS_PER_TENTH - 1));
   assign expire    = armed && run && !load && !kick && tick_edge && (remain == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         reload <= '0;
         remain <= '0;
         pre    <= '0;
      end else if (srst) begin
         armed  <= 1'b0;
         reload <= '0;
         remain <= '0;
         pre    <= '0;
      end else if (load) begin
         armed  <= (count != 8'd0);
         reload <= load_val;
         remain <= load_val;
         pre    <= '0;
      end else if (kick) begin
         remain <= reload;
         pre    <= '0;
      end else if (armed && run && remain != '0) begin
         if (tick_edge) begin
            pre    <= '0;
            remain <= remain - CNT_W'(1);
         end else begin
            pre <= pre + PRE_W'(1);
         end
      end
   end

   // R13: the countdown never exceeds the programmed timeout
   a_r13_remain_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      remain <= reload);

   // R13: expiry is a single-cycle event
   a_r13_expire_single: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);

endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
   import ata_tf_pkg::*;
#(
   parameter int DATA_W          = 16,
   parameter int TICKS_PER_TENTH = 10_000_000,
   parameter int LONG_UNIT       = 50,
   parameter bit IDLE_TIMER_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs0_n,
   input  logic              cs1_n,
   input  logic [2:0]        addr,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              intrq,
   output logic              cmd_stb,
   output logic [7:0]        cmd_code,
   output logic              dp_rd_stb,
   output logic              dp_wr_stb,
   output logic [DATA_W-1:0] dp_wdata,
   input  logic [DATA_W-1:0] be_rdata,
   input  logic              be_drq,
   input  logic              be_done,
   input  logic              be_fail,
   input  logic [7:0]        be_error,
   output logic              spindle_on
);

   localparam int REG_W = 8;

   if (DATA_W < REG_W) begin : g_bad_width
      $error("DATA_W must hold at least one register byte");
   end
   if (TICKS_PER_TENTH < 2) begin : g_bad_ticks
      $error("TICKS_PER_TENTH must be at least 2");
   end
   if (LONG_UNIT < 1) begin : g_bad_unit
      $error("LONG_UNIT must be positive");
   end

   tf_sel_e          sel;
   logic [REG_W-1:0] wr_byte;
   logic             srst;
   logic             bsy, cmd_acc, err, pend, writing;
   logic             timer_load, timer_long, timer_expire, timer_kick;
   logic [REG_W-1:0] err_reg;
   logic [REG_W-1:0] scount, snumber, cyl_lo, cyl_hi;
   logic [4:0]       dev_head;
   logic             nien;
   logic [REG_W-1:0] status_b, drvhd_b, drvadr_b;
   logic [REG_W-1:0] byte_rd;

   assign wr_byte = wr_data[REG_W-1:0];
   assign srst    = wr_stb && (sel == SEL_ALTCTL) && wr_byte[DC_SRST];

   ata_tf_decode u_decode (
      .cs0_n (cs0_n),
      .cs1_n (cs1_n),
      .addr  (addr),
      .sel   (sel)
   );

   ata_tf_regs #(.REG_W(REG_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .srst     (srst),
      .wr_stb   (wr_stb),
      .sel      (sel),
      .wr_byte  (wr_byte),
      .bsy      (bsy),
      .scount   (scount),
      .snumber  (snumber),
      .cyl_lo   (cyl_lo),
      .cyl_hi   (cyl_hi),
      .dev_head (dev_head),
      .nien     (nien)
   );

   ata_tf_cmd #(.REG_W(REG_W)) u_cmd (
      .clk          (clk),
      .rst_n        (rst_n),
      .srst         (srst),
      .cmd_wr       (wr_stb && sel == SEL_STATCMD),
      .wr_byte      (wr_byte),
      .stat_rd      (rd_stb && sel == SEL_STATCMD),
      .nien         (nien),
      .be_done      (be_done),
      .be_fail      (be_fail),
      .be_error     (be_error),
      .timer_expire (timer_expire),
      .bsy          (bsy),
      .cmd_acc      (cmd_acc),
      .err          (err),
      .err_reg      (err_reg),
      .pend         (pend),
      .cmd_stb      (cmd_stb),
      .cmd_code     (cmd_code),
      .spindle      (spindle_on),
      .writing      (writing),
      .timer_load   (timer_load),
      .timer_long   (timer_long)
   );

   assign dp_rd_stb  = rd_stb && (sel == SEL_DATA);
   assign dp_wr_stb  = wr_stb && (sel == SEL_DATA);
   assign dp_wdata   = wr_data;
   assign timer_kick = cmd_acc || dp_rd_stb || dp_wr_stb;

   if (IDLE_TIMER_EN) begin : g_timer
      ata_tf_idle_timer #(
         .TICKS_PER_TENTH (TICKS_PER_TENTH),
         .LONG_UNIT       (LONG_UNIT)
      ) u_timer (
         .clk        (clk),
         .rst_n      (rst_n),
         .srst       (srst),
         .load       (timer_load),
         .long_units (timer_long),
         .count      (scount),
         .kick       (timer_kick),
         .run        (spindle_on && !bsy),
         .expire     (timer_expire)
      );
   end else begin : g_no_timer
      assign timer_expire = 1'b0;
   end

   always_comb begin
      status_b         = '0;
      status_b[ST_BSY] = bsy;
      status_b[ST_RDY] = !bsy;
      status_b[ST_DSC] = !bsy;
      status_b[ST_DRQ] = be_drq;
      status_b[ST_ERR] = err;
   end

   assign drvhd_b  = {3'b101, dev_head};
   assign drvadr_b = {1'b0, writing, ~dev_head[3:0], dev_head[4], ~dev_head[4]};

   always_comb begin
      case (sel)
         SEL_ERRFEAT:             byte_rd = err_reg;
         SEL_SCNT:                byte_rd = scount;
         SEL_SNUM:                byte_rd = snumber;
         SEL_CYLL:                byte_rd = cyl_lo;
         SEL_CYLH:                byte_rd = cyl_hi;
         SEL_DRVHD:               byte_rd = drvhd_b;
         SEL_STATCMD, SEL_ALTCTL: byte_rd = status_b;
         SEL_DRVADR:              byte_rd = drvadr_b;
         default:                 byte_rd = '0;
      endcase
   end

   assign rd_data = (sel == SEL_DATA) ? be_rdata : DATA_W'(byte_rd);
   assign intrq   = pend && !nien;

   // R7: reading alternate status keeps a raised interrupt
   a_r7_alt_read_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !wr_stb && sel == SEL_ALTCTL && intrq) |=> intrq);

   // R1: a conflicting or empty chip-select pair reads as zero
   a_r1_bad_select_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cs0_n == cs1_n) |-> (rd_data == '0));

endmodule

// File: tb/ata_taskfile_regs_tb_top.sv
module ata_taskfile_regs_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs0_n = 1'b1, cs1_n = 1'b1;
   logic [2:0]  addr = '0;
   logic        rd_stb = 1'b0, wr_stb = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        intrq, cmd_stb, dp_rd_stb, dp_wr_stb, spindle_on;
   logic [7:0]  cmd_code;
   logic [15:0] dp_wdata;
   logic [15:0] be_rdata = '0;
   logic        be_drq = 1'b0, be_done = 1'b0, be_fail = 1'b0;
   logic [7:0]  be_error = '0;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #5 clk = ~clk;

   ata_taskfile_regs #(
      .DATA_W          (16),
      .TICKS_PER_TENTH (4),
      .LONG_UNIT       (50),
      .IDLE_TIMER_EN   (1'b1)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .cs0_n (cs0_n), .cs1_n (cs1_n), .addr (addr),
      .rd_stb (rd_stb), .wr_stb (wr_stb), .wr_data (wr_data), .rd_data (rd_data),
      .intrq (intrq), .cmd_stb (cmd_stb), .cmd_code (cmd_code),
      .dp_rd_stb (dp_rd_stb), .dp_wr_stb (dp_wr_stb), .dp_wdata (dp_wdata),
      .be_rdata (be_rdata), .be_drq (be_drq), .be_done (be_done),
      .be_fail (be_fail), .be_error (be_error), .spindle_on (spindle_on)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic c0, input logic c1, input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      cs0_n = c0; cs1_n = c1; addr = a; wr_data = d; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0; cs0_n = 1'b1; cs1_n = 1'b1;
   endtask

   task automatic rd(input logic c0, input logic c1, input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      cs0_n = c0; cs1_n = c1; addr = a; rd_stb = 1'b1;
      #1 d = rd_data;
      @(negedge clk);
      rd_stb = 1'b0; cs0_n = 1'b1; cs1_n = 1'b1;
   endtask

   task automatic peek(input logic c0, input logic c1, input logic [2:0] a, output logic [15:0] d);
      cs0_n = c0; cs1_n = c1; addr = a;
      #1 d = rd_data;
      cs0_n = 1'b1; cs1_n = 1'b1;
   endtask

   task automatic finish_cmd(input logic f, input logic [7:0] e);
      @(negedge clk);
      be_done = 1'b1; be_fail = f; be_error = e;
      @(negedge clk);
      be_done = 1'b0; be_fail = 1'b0; be_error = '0;
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [15:0] d;
      logic [7:0]  v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 reset state
      peek(0, 1, 2, d); chk("R2 scount", d, 16'h01);
      peek(0, 1, 3, d); chk("R2 snumber", d, 16'h01);
      peek(0, 1, 4, d); chk("R2 cyl_lo", d, 16'h00);
      peek(0, 1, 5, d); chk("R2 cyl_hi", d, 16'h00);
      peek(0, 1, 6, d); chk("R2 drvhd", d, 16'hA0);
      peek(0, 1, 7, d); chk("R2 status", d, 16'h50);
      peek(0, 1, 1, d); chk("R2 error", d, 16'h00);
      peek(1, 0, 7, d); chk("R2 drvaddr", d, 16'h3D);
      chk("R2 intrq", intrq, 0);
      chk("R2 spindle", spindle_on, 1);

      // R1 byte register sweep
      for (int i = 0; i < 256; i++) begin
         v = 8'(i);
         wr(0, 1, 2, {8'h00, v});
         wr(0, 1, 3, {8'h00, v ^ 8'h5A});
         wr(0, 1, 4, {8'h00, ~v});
         wr(0, 1, 5, {8'h00, v + 8'd7});
         rd(0, 1, 2, d); chk("R1 scount", d, {8'h00, v});
         rd(0, 1, 3, d); chk("R1 snumber", d, {8'h00, v ^ 8'h5A});
         rd(0, 1, 4, d); chk("R1 cyl_lo", d, {8'h00, ~v});
         rd(0, 1, 5, d); chk("R1 cyl_hi", d, {8'h00, v + 8'd7});
      end

      // R3 and R4 drive/head and drive address sweep
      for (int i = 0; i < 256; i++) begin
         v = 8'(i);
         wr(0, 1, 6, {8'h00, v});
         rd(0, 1, 6, d); chk("R3 drvhd", d, {8'h00, 3'b101, v[4:0]});
         rd(1, 0, 7, d); chk("R4 drvaddr", d, {8'h00, 2'b00, ~v[3:0], v[4], ~v[4]});
      end

      // R1 invalid selects
      for (int a = 0; a < 8; a++) begin
         peek(0, 0, 3'(a), d); chk("R1 both selects", d, 0);
         peek(1, 1, 3'(a), d); chk("R1 no select", d, 0);
         if (a < 6) begin
            peek(1, 0, 3'(a), d); chk("R1 ctl hole", d, 0);
         end
      end
      wr(0, 0, 2, 16'h0099);
      wr(1, 0, 2, 16'h0098);
      rd(0, 1, 2, d); chk("R1 ignored writes", d, 16'h00FF);

      // R6 media command handoff
      wr(0, 1, 2, 16'h0011);
      wr(0, 1, 7, 16'h0020);
      chk("R6 cmd_stb", cmd_stb, 1);
      chk("R6 cmd_code", cmd_code, 8'h20);
      peek(0, 1, 7, d); chk("R6 busy status", d, 16'h80);
      @(negedge clk);
      chk("R6 strobe single", cmd_stb, 0);

      // R5 writes while busy
      wr(0, 1, 2, 16'h0033);
      wr(0, 1, 6, 16'h0001);
      wr(0, 1, 7, 16'h00E0);
      chk("R5 cmd ignored strobe", cmd_stb, 0);
      chk("R5 cmd ignored spindle", spindle_on, 1);

      // R14 data port
      be_drq = 1'b1; be_rdata = 16'hBEEF;
      peek(0, 1, 7, d); chk("R14 drq status", d, 16'h88);
      @(negedge clk);
      cs0_n = 0; cs1_n = 1; addr = 0; rd_stb = 1'b1;
      #1 chk("R14 read word", rd_data, 16'hBEEF);
      chk("R14 read strobe", dp_rd_stb, 1);
      @(negedge clk);
      rd_stb = 1'b0;
      cs0_n = 0; cs1_n = 1; addr = 0; wr_data = 16'h1234; wr_stb = 1'b1;
      #1 chk("R14 write strobe", dp_wr_stb, 1);
      chk("R14 write word", dp_wdata, 16'h1234);
      @(negedge clk);
      wr_stb = 1'b0; cs0_n = 1; cs1_n = 1;
      #1 chk("R14 strobe idle", dp_wr_stb, 0);
      be_drq = 1'b0;

      finish_cmd(0, 8'h00);
      chk("R6 intrq", intrq, 1);
      peek(0, 1, 7, d); chk("R6 done status", d, 16'h50);
      rd(0, 1, 2, d); chk("R5 scount kept", d, 16'h0011);
      rd(0, 1, 6, d); chk("R5 drvhd kept", d, 16'h00BF);

      // R7 alternate versus primary status
      rd(1, 0, 6, d); chk("R7 alt status", d, 16'h50);
      chk("R7 alt keeps intrq", intrq, 1);
      rd(0, 1, 7, d); chk("R7 primary status", d, 16'h50);
      chk("R7 primary clears intrq", intrq, 0);

      // R8 masked interrupts
      wr(1, 0, 6, 16'h0002);
      wr(0, 1, 7, 16'h00EC);
      chk("R8 cmd_stb", cmd_stb, 1);
      finish_cmd(0, 8'h00);
      chk("R8 no intrq", intrq, 0);
      wr(1, 0, 6, 16'h0000);
      chk("R8 unmask no intrq", intrq, 0);

      // R10 backend failure and R4 writing bit
      wr(0, 1, 7, 16'h0030);
      peek(1, 0, 7, d); chk("R4 writing bit", d, 16'h42);
      finish_cmd(1, 8'h10);
      peek(0, 1, 7, d); chk("R10 status err", d, 16'h51);
      peek(0, 1, 1, d); chk("R10 error reg", d, 16'h10);
      peek(1, 0, 7, d); chk("R4 writing clear", d, 16'h02);
      chk("R10 intrq", intrq, 1);

      // R9 unknown command
      wr(0, 1, 7, 16'h0055);
      chk("R9 no strobe", cmd_stb, 0);
      chk("R6 accept clears intrq", intrq, 0);
      peek(0, 1, 7, d); chk("R9 busy", d, 16'h80);
      @(negedge clk);
      peek(0, 1, 7, d); chk("R9 status err", d, 16'h51);
      peek(0, 1, 1, d); chk("R9 aborted", d, 16'h04);
      chk("R9 intrq", intrq, 1);
      wr(0, 1, 7, 16'h0010);
      peek(0, 1, 1, d); chk("R6 error cleared", d, 16'h00);
      finish_cmd(0, 8'h00);

      // R12 power commands
      wr(0, 1, 7, 16'h00E0);
      @(negedge clk);
      chk("R12 E0 off", spindle_on, 0);
      peek(0, 1, 7, d); chk("R12 status", d, 16'h50);
      wr(0, 1, 7, 16'h00E1);
      @(negedge clk);
      chk("R12 E1 on", spindle_on, 1);
      wr(0, 1, 2, 16'h0000);
      wr(0, 1, 7, 16'h00E2);
      @(negedge clk);
      chk("R12 E2 off", spindle_on, 0);
      wr(0, 1, 7, 16'h0070);
      chk("R12 media on", spindle_on, 1);
      finish_cmd(0, 8'h00);
      wr(0, 1, 2, 16'h0000);
      wr(0, 1, 7, 16'h00F2);
      @(negedge clk);
      chk("R12 F2 off", spindle_on, 0);
      wr(0, 1, 7, 16'h00F3);
      @(negedge clk);
      chk("R12 F3 on", spindle_on, 1);
      repeat (300) @(negedge clk);
      chk("R13 zero count disarmed", spindle_on, 1);

      // R13 short units: 3 ticks of 4 cycles
      wr(0, 1, 2, 16'h0003);
      wr(0, 1, 7, 16'h00F3);
      repeat (6) @(negedge clk);
      chk("R13 short before", spindle_on, 1);
      repeat (14) @(negedge clk);
      chk("R13 short after", spindle_on, 0);

      // R13 restart by data access
      wr(0, 1, 7, 16'h00F3);
      repeat (6) @(negedge clk);
      rd(0, 1, 0, d);
      repeat (8) @(negedge clk);
      chk("R13 kick delays", spindle_on, 1);
      repeat (12) @(negedge clk);
      chk("R13 kick then off", spindle_on, 0);

      // R13 long units: 1 x 50 ticks of 4 cycles
      wr(0, 1, 2, 16'h0001);
      wr(0, 1, 7, 16'h00E3);
      repeat (150) @(negedge clk);
      chk("R13 long before", spindle_on, 1);
      repeat (100) @(negedge clk);
      chk("R13 long after", spindle_on, 0);

      // R11 software reset
      wr(0, 1, 2, 16'h0077);
      wr(0, 1, 6, 16'h0012);
      wr(1, 0, 6, 16'h0002);
      wr(0, 1, 7, 16'h0020);
      wr(1, 0, 6, 16'h0004);
      peek(0, 1, 7, d); chk("R11 status", d, 16'h50);
      peek(0, 1, 2, d); chk("R11 scount", d, 16'h01);
      peek(0, 1, 3, d); chk("R11 snumber", d, 16'h01);
      peek(0, 1, 6, d); chk("R11 drvhd", d, 16'hA0);
      peek(0, 1, 1, d); chk("R11 error", d, 16'h00);
      chk("R11 spindle", spindle_on, 1);
      chk("R11 intrq", intrq, 0);
      wr(0, 1, 7, 16'h0010);
      finish_cmd(0, 8'h00);
      chk("R11 mask cleared", intrq, 1);

      summary();
   end

endmodule